// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. It has a 32-bit up-counter. The counter advances on a tick-enable input, either on every tick or, when the prescaler is on, once every 2^k ticks. When the counter passes all-ones, the block raises a reset request for one clock cycle and refills the counter from a load register. Software keeps the system alive by writing a new value to the trigger register. Any written value that differs from the stored one copies the load register into the counter. Software can also write the counter directly, for example to force an early reset.

Starting or stopping the timer takes a two-word key written to the start/stop register. A single stray write therefore cannot change the run state. A write to a register is held busy for a fixed number of cycles, which stands in for a clock-domain crossing. A status register shows which registers are still busy, and a write to a busy register is dropped.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the counter, load, trigger, control and posting-status registers read 0, the timer is stopped and `rst_req` is 0.
- R2: Byte offset 0x00 reads the revision, with the major number in bits 7:4 and the minor number in bits 3:0 (defaults 2 and 1, so 0x21). Writes to this offset have no effect.
- R3: The timer starts when a write of 0x0000BBBB to the start/stop register (offset 0x48) is followed by a write of 0x00004444 as the next accepted start/stop write. Writes to other registers in between do not break the pair.
- R4: The timer stops when a write of 0x0000AAAA to offset 0x48 is followed by a write of 0x00005555 as the next accepted start/stop write.
- R5: Any other start/stop write abandons a pending key. This includes a mismatched second word, such as 0xAAAA followed by 0x4444 or 0xBBBB followed by 0x5555. The run state is then unchanged.
- R6: The posting status register (offset 0x34) has one bit per register: bit 0 control (0x24), bit 1 counter (0x28), bit 2 load (0x2C), bit 3 trigger (0x30), bit 4 start/stop (0x48). A bit reads 1 for exactly 4 clock cycles after its register accepts a write.
- R7: A write to a register whose posting bit is 1 is ignored.
- R8: While the timer runs with the prescaler off, the counter (offset 0x28) rises by one on every cycle with `tick_en` high. While the timer is stopped, ticks leave it unchanged.
- R9: Control bit 5 enables the prescaler, and control bits 4:2 hold an exponent k. With the prescaler on, the counter rises once per 2^k running ticks. Writing control, counter or trigger clears the partial prescale count.
- R10: A trigger write (offset 0x30) whose value differs from the stored trigger value copies the load register (offset 0x2C) into the counter. A write of the same value leaves the counter unchanged.
- R11: A tick that advances the counter from 0xFFFFFFFF makes `rst_req` high for exactly the next cycle and loads the counter from the load register. Starting from 0xFFFFFF80, the 128th tick causes this.
- R12: A write to offset 0x28 sets the counter directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick, one cycle per tick |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
The bench sweeps the wrap boundary from several counter values just below all-ones. A design that pulsed one tick early or late, held the request for two cycles, or kept counting from zero instead of the load value would be caught there.

Each register's busy window is measured cycle by cycle, and a write is issued into that window. This exposes a wrong status bit position, an off-by-one window, or a busy write that still lands.

Key pairs are tried with foreign and crossed second words. A sequencer that accepted either word order, or did not reset on a stray word, would start or stop the timer.

The prescaler exponent is swept, along with same-value and new-value trigger writes. This catches a wrong divide ratio and a refresh on any trigger write rather than on a changed one.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PEND_CYC  = 4,
  parameter int PSC_EXP_W = 3,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int NREG  = 5;
  localparam int PC_W  = $clog2(PEND_CYC + 1);
  localparam int PSC_W = (1 << PSC_EXP_W) - 1;

  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_POST = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(8'h48);

  localparam logic [DATA_W-1:0] KEY_RUN1  = DATA_W'(16'hBBBB);
  localparam logic [DATA_W-1:0] KEY_RUN2  = DATA_W'(16'h4444);
  localparam logic [DATA_W-1:0] KEY_STOP1 = DATA_W'(16'hAAAA);
  localparam logic [DATA_W-1:0] KEY_STOP2 = DATA_W'(16'h5555);
  localparam logic [7:0]        REV       = 8'(((REV_MAJOR & 15) << 4) | (REV_MINOR & 15));

  typedef enum logic [1:0] {K_IDLE, K_RUN1, K_STOP1} key_stage_t;

  logic [NREG-1:0]      sel, pend, acc;
  logic [DATA_W-1:0]    cnt_q, load_q, trig_q;
  logic [PSC_EXP_W:0]   ctrl_q;
  logic [PSC_W-1:0]     psc_q, psc_mask;
  logic [PSC_W:0]       one_sh, one_sh_m1;
  logic                 run_q, rst_req_q;
  key_stage_t           stage_q;
  logic                 pre_en, tick_go, adv, wrap, trig_rl, acc_cnt;

  assign sel = {bus_addr == A_KEY, bus_addr == A_TRIG, bus_addr == A_LOAD,
                bus_addr == A_CNT, bus_addr == A_CTRL};
  assign acc = {NREG{bus_we}} & sel & ~pend;

  for (genvar i = 0; i < NREG; i++) begin : g_post
    logic [PC_W-1:0] left_q;
    always_ff @(posedge clk) begin
      if (!rst_n)            left_q <= '0;
      else if (acc[i])       left_q <= PC_W'(PEND_CYC);
      else if (left_q != '0) left_q <= left_q - PC_W'(1);
    end
    assign pend[i] = left_q != '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
    end else begin
      if (acc[0]) ctrl_q <= bus_wdata[PSC_EXP_W+2:2];
      if (acc[2]) load_q <= bus_wdata;
      if (acc[3]) trig_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      stage_q <= K_IDLE;
    end else if (acc[4]) begin
      if (bus_wdata == KEY_RUN2 && stage_q == K_RUN1)   run_q <= 1'b1;
      if (bus_wdata == KEY_STOP2 && stage_q == K_STOP1) run_q <= 1'b0;
      if (bus_wdata == KEY_RUN1)       stage_q <= K_RUN1;
      else if (bus_wdata == KEY_STOP1) stage_q <= K_STOP1;
      else                             stage_q <= K_IDLE;
    end
  end

  assign pre_en    = ctrl_q[PSC_EXP_W];
  assign one_sh    = (PSC_W+1)'(1) << ctrl_q[PSC_EXP_W-1:0];
  assign one_sh_m1 = one_sh - (PSC_W+1)'(1);
  assign psc_mask  = one_sh_m1[PSC_W-1:0];
  assign tick_go   = run_q && tick_en;
  assign adv       = tick_go && (!pre_en || psc_q == psc_mask);
  assign wrap      = adv && (&cnt_q);
  assign acc_cnt   = acc[1];
  assign trig_rl   = acc[3] && bus_wdata != trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                               psc_q <= '0;
    else if (acc[0] || acc_cnt || trig_rl || adv) psc_q <= '0;
    else if (tick_go && pre_en)               psc_q <= psc_q + PSC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      if (acc_cnt)      cnt_q <= bus_wdata;
      else if (trig_rl) cnt_q <= load_q;
      else if (wrap) begin
        cnt_q     <= load_q;
        rst_req_q <= 1'b1;
      end else if (adv) cnt_q <= cnt_q + DATA_W'(1);
    end
  end

  assign rst_req = rst_req_q;

  always_comb begin
    unique case (bus_addr)
      A_ID:    bus_rdata = DATA_W'(REV);
      A_CTRL:  bus_rdata = DATA_W'({ctrl_q, 2'b00});
      A_CNT:   bus_rdata = cnt_q;
      A_LOAD:  bus_rdata = load_q;
      A_TRIG:  bus_rdata = trig_q;
      A_POST:  bus_rdata = DATA_W'(pend);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              run_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] load_q,
  input logic [4:0]        pend,
  input logic              rst_req,
  input logic              acc_cnt,
  input logic              trig_rl
);
  localparam logic [ADDR_W-1:0] C_LOAD = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] C_KEY  = ADDR_W'(8'h48);
  localparam logic [DATA_W-1:0] C_GO   = DATA_W'(16'h4444);
  localparam logic [DATA_W-1:0] C_HALT = DATA_W'(16'h5555);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R11
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt_q == $past(load_q)); // R11
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(run_q)); // R11
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !acc_cnt && !trig_rl) |=> cnt_q == $past(cnt_q)); // R8
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_LOAD && pend[2]) |=> load_q == $past(load_q)); // R7
  AST_START_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(bus_we && bus_addr == C_KEY && bus_wdata == C_GO)); // R3
  AST_STOP_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(bus_we && bus_addr == C_KEY && bus_wdata == C_HALT)); // R4
endmodule

bind wdt_keyed wdt_keyed_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run_q(run_q), .cnt_q(cnt_q), .load_q(load_q),
  .pend(pend), .rst_req(rst_req), .acc_cnt(acc_cnt), .trig_rl(trig_rl)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PEND       = 4;
  localparam logic [7:0] O_ID = 8'h00, O_CTRL = 8'h24, O_CNT = 8'h28, O_LOAD = 8'h2C,
                         O_TRIG = 8'h30, O_POST = 8'h34, O_KEY = 8'h48;

  logic        clk = 0, rst_n = 0, tick_en = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rst_req;
  int          n_chk = 0, n_fail = 0;
  logic        done = 0;

  wdt_keyed u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
                   .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                   .rst_req(rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_raw(a, d);
    repeat (PEND) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic start_wd(); wr(O_KEY, 32'hBBBB); wr(O_KEY, 32'h4444); endtask
  task automatic stop_wd();  wr(O_KEY, 32'hAAAA); wr(O_KEY, 32'h5555); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 counter", O_CNT, 0);
    rd_chk("R1 load", O_LOAD, 0);
    rd_chk("R1 trigger", O_TRIG, 0);
    rd_chk("R1 control", O_CTRL, 0);
    rd_chk("R1 posting", O_POST, 0);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    ticks(5);
    rd_chk("R1 stopped after reset", O_CNT, 0);

    // R2 identification
    rd_chk("R2 revision", O_ID, 32'h21);
    wr(O_ID, 32'hFFFF_FFFF);
    rd_chk("R2 write ignored", O_ID, 32'h21);

    // R6 posting window per register, R7 busy write dropped
    begin
      logic [7:0] offs [5] = '{O_CTRL, O_CNT, O_LOAD, O_TRIG, O_KEY};
      for (int i = 0; i < 5; i++) begin
        wr_raw(offs[i], 32'h0);
        rd_chk("R6 busy bit set", O_POST, 32'(1 << i));
        repeat (PEND - 1) @(negedge clk);
        rd_chk("R6 busy last cycle", O_POST, 32'(1 << i));
        @(negedge clk);
        rd_chk("R6 busy cleared", O_POST, 0);
      end
    end
    wr_raw(O_LOAD, 32'h1111);
    wr_raw(O_LOAD, 32'h2222);
    rd_chk("R7 busy write ignored", O_LOAD, 32'h1111);
    repeat (PEND) @(negedge clk);
    wr(O_LOAD, 32'h3333);
    rd_chk("R7 write after window", O_LOAD, 32'h3333);

    // R12 direct counter write, R8 hold while stopped
    wr(O_CNT, 32'h0000_0010);
    rd_chk("R12 counter written", O_CNT, 32'h10);
    ticks(7);
    rd_chk("R8 stopped hold", O_CNT, 32'h10);

    // R3 start, R8 counting
    start_wd();
    ticks(9);
    rd_chk("R8 count per tick", O_CNT, 32'h19);
    // R4 stop
    stop_wd();
    ticks(4);
    rd_chk("R4 stopped", O_CNT, 32'h19);

    // R5 broken/crossed sequences
    wr(O_KEY, 32'hBBBB); wr(O_KEY, 32'h1234); wr(O_KEY, 32'h4444);
    ticks(3);
    rd_chk("R5 foreign word between", O_CNT, 32'h19);
    wr(O_KEY, 32'hAAAA); wr(O_KEY, 32'h4444);
    ticks(3);
    rd_chk("R5 crossed start", O_CNT, 32'h19);
    // R3 other-register write between keys does not break pair
    wr(O_KEY, 32'hBBBB); wr(O_LOAD, 32'h50); wr(O_KEY, 32'h4444);
    ticks(2);
    rd_chk("R3 start across other write", O_CNT, 32'h1B);
    wr(O_KEY, 32'hBBBB); wr(O_KEY, 32'h5555);
    ticks(2);
    rd_chk("R5 crossed stop keeps running", O_CNT, 32'h1D);
    stop_wd();

    // R10 trigger refresh
    wr(O_LOAD, 32'hABC);
    wr(O_CNT, 32'h5);
    wr(O_TRIG, 32'h1);
    rd_chk("R10 new value reloads", O_CNT, 32'hABC);
    wr(O_CNT, 32'h7);
    wr(O_TRIG, 32'h1);
    rd_chk("R10 same value no reload", O_CNT, 32'h7);
    wr(O_TRIG, 32'h2);
    rd_chk("R10 changed value reloads", O_CNT, 32'hABC);

    // R9 prescaler sweep
    for (int e = 0; e < 4; e++) begin
      wr(O_CTRL, 32'((1 << 5) | (e << 2)));
      rd_chk("R9 control readback", O_CTRL, 32'((1 << 5) | (e << 2)));
      wr(O_CNT, 0);
      start_wd();
      ticks(20);
      rd_chk("R9 prescaled count", O_CNT, 32'(20 >> e));
      stop_wd();
    end
    wr(O_CTRL, 32'(3 << 2));
    wr(O_CNT, 0);
    start_wd();
    ticks(20);
    rd_chk("R9 prescaler disabled", O_CNT, 32'd20);
    stop_wd();
    wr(O_CTRL, 0);

    // R11 wrap sweep
    for (int k = 1; k <= 6; k++) begin
      wr(O_LOAD, 32'(256 + k));
      wr(O_CNT, 32'(-k));
      start_wd();
      ticks(k - 1);
      rd_chk("R11 before wrap", O_CNT, 32'hFFFF_FFFF);
      chk("R11 no early request", {31'b0, rst_req}, 0);
      tick_en = 1;
      @(negedge clk);
      tick_en = 0;
      chk("R11 request pulse", {31'b0, rst_req}, 1);
      rd_chk("R11 reload after wrap", O_CNT, 32'(256 + k));
      @(negedge clk);
      chk("R11 request one cycle", {31'b0, rst_req}, 0);
      stop_wd();
    end
    wr(O_LOAD, 32'h77);
    wr(O_CNT, 32'hFFFF_FF80);
    start_wd();
    ticks(127);
    chk("R11 no request at 127", {31'b0, rst_req}, 0);
    tick_en = 1;
    @(negedge clk);
    tick_en = 0;
    chk("R11 request at 128", {31'b0, rst_req}, 1);
    rd_chk("R11 reload at 128", O_CNT, 32'h77);
    stop_wd();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule